// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block sits on the host side of a parallel NOR-style flash bus and writes a run of consecutive words into the device. After a start pulse it takes one word from a valid/ready data source, drives the unlock and program command writes for that word, and then reads the device status at the word address. It keeps reading until bit 7 of the status equals bit 7 of the data just written. A final read compares the whole word, after which the sequencer moves to the next address. The run ends with a done flag after the last word, or with an error flag and a latched failing address.

A mode input chooses between two command forms. In full mode every word is preceded by the two unlock writes and the program command. In shortened mode the device is put into its bypass state once at the start of the run. Each word then needs only the program command and the data write, and the run ends with a two-write exit pair. The bus is a simple synchronous master: a write strobe lasts one cycle, and a read strobe lasts one cycle with read data returned on the following cycle.

Top module: `flash_prog_loop`

## Requirements
- R1: While reset is held and right after it, busWr, busRd, srcReady, done and error are all low and failAddr is zero.
- R2: In full mode (bypassMode=0), each word is preceded by three writes in this order: data AAh at address 555h, 55h at 2AAh, and A0h at 555h. The fourth write puts the source word at the current word address.
- R3: In shortened mode (bypassMode=1), the run opens once with writes AAh@555h, 55h@2AAh and 20h@555h. After that, each word uses only A0h@555h followed by the source word at the current word address.
- R4: A shortened-mode run that completes issues 90h@000h and then 00h@000h after the last word's verify read. done rises on the cycle after the second of these writes.
- R5: After the data write, the block reads the word address. A read whose bit 7 differs from bit 7 of the written word causes another read. A matching read ends polling.
- R6: After polling ends, one verify read is made at the word address. If the returned word differs from the written word, error rises two cycles after that read, failAddr holds the word address, and no further bus cycles occur.
- R7: If POLL_LIMIT consecutive status reads all mismatch, error rises two cycles after the last of them, failAddr holds the word address, and no further bus cycles occur. A match on read number POLL_LIMIT still succeeds.
- R8: Word k of a run goes to startAddr+k for k from 0 to wordCount-1. In full mode, done rises two cycles after the last verify read.
- R9: srcReady is high only while the block waits for the next word, and never in the same cycle as a bus strobe. Exactly one source word is taken per address attempted.
- R10: A start with wordCount=0 raises done on the next cycle without any bus cycle or source handshake.
- R11: done and error are never high together, busWr and busRd are never high together, and both flags stay high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run; taken only when idle, done or failed |
| bypassMode | input | 1 | 1 selects the shortened command form for the run |
| startAddr | input | AW | First word address of the run |
| wordCount | input | CW | Number of words to program |
| srcData | input | DW | Next word from the data source |
| srcValid | input | 1 | Data source offers srcData |
| srcReady | output | 1 | Block takes srcData on this cycle if srcValid |
| busAddr | output | AW | Bus word address |
| busWdata | output | DW | Bus write data |
| busWr | output | 1 | One-cycle bus write strobe |
| busRd | output | 1 | One-cycle bus read strobe |
| busRdata | input | DW | Read data, valid the cycle after busRd |
| done | output | 1 | Run finished successfully |
| error | output | 1 | Run stopped on poll timeout or verify mismatch |
| failAddr | output | AW | Word address where the run stopped |

## Verification
The bench samples at the falling clock edge. Each strobe it sees there is compared in order against an expected queue of writes and reads built from the requirements. For each read, the bench returns the response on the following cycle, since the block samples read data one cycle after its read strobe. Completion is timed against the last strobe: done is due two cycles after the last verify read in full mode and one cycle after the second exit write in shortened mode. error is due two cycles after the failing read, and done for a zero count is due on the cycle after start. The bench checks the flags and failAddr only after these points.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_UNLOCK_A,
    SEL_UNLOCK_B,
    SEL_PROG,
    SEL_WORD,
    SEL_BYP_ENTER,
    SEL_EXIT_A,
    SEL_EXIT_B,
    SEL_READ
  } busSel_e;

  typedef struct packed {
    logic    loadStart;
    logic    loadData;
    logic    clrTimer;
    logic    incTimer;
    logic    advance;
    logic    latchFail;
    busSel_e sel;
  } ctrlStrobe_t;

  localparam logic [11:0] ADR_UNLOCK_A = 12'h555;
  localparam logic [11:0] ADR_UNLOCK_B = 12'h2AA;
  localparam logic [11:0] ADR_EXIT     = 12'h000;

  localparam logic [7:0] CMD_UNLOCK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B  = 8'h55;
  localparam logic [7:0] CMD_PROG      = 8'hA0;
  localparam logic [7:0] CMD_BYP_ENTER = 8'h20;
  localparam logic [7:0] CMD_EXIT_A    = 8'h90;
  localparam logic [7:0] CMD_EXIT_B    = 8'h00;

endpackage

// File: rtl/fpl_datapath.sv
module fpl_datapath
  import fpl_pkg::*;
#(
  parameter int AW         = 23,
  parameter int DW         = 16,
  parameter int CW         = 24,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   stb,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] wordCount,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic [AW-1:0] failAddr,
  output logic          countZero,
  output logic          isLast,
  output logic          pollMatch,
  output logic          verifyOk,
  output logic          timeoutHit
);

  localparam int TW = $clog2(POLL_LIMIT + 1);

  logic [AW-1:0] curAddr;
  logic [CW-1:0] remaining;
  logic [DW-1:0] dataReg;
  logic [TW-1:0] pollTimer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
      dataReg   <= '0;
      pollTimer <= '0;
      failAddr  <= '0;
    end else begin
      if (stb.loadStart) begin
        curAddr   <= startAddr;
        remaining <= wordCount;
      end else if (stb.advance) begin
        curAddr   <= curAddr + AW'(1);
        remaining <= remaining - CW'(1);
      end
      if (stb.loadData) dataReg <= srcData;
      if (stb.clrTimer)      pollTimer <= '0;
      else if (stb.incTimer) pollTimer <= pollTimer + TW'(1);
      if (stb.latchFail) failAddr <= curAddr;
    end
  end

  assign countZero  = (wordCount == '0);
  assign isLast     = (remaining == CW'(1));
  assign pollMatch  = (busRdata[7] == dataReg[7]);
  assign verifyOk   = (busRdata == dataReg);
  assign timeoutHit = (pollTimer == TW'(POLL_LIMIT - 1));

  always_comb begin
    busAddr  = curAddr;
    busWdata = dataReg;
    case (stb.sel)
      SEL_UNLOCK_A:  begin busAddr = AW'(ADR_UNLOCK_A); busWdata = DW'(CMD_UNLOCK_A);  end
      SEL_UNLOCK_B:  begin busAddr = AW'(ADR_UNLOCK_B); busWdata = DW'(CMD_UNLOCK_B);  end
      SEL_PROG:      begin busAddr = AW'(ADR_UNLOCK_A); busWdata = DW'(CMD_PROG);      end
      SEL_BYP_ENTER: begin busAddr = AW'(ADR_UNLOCK_A); busWdata = DW'(CMD_BYP_ENTER); end
      SEL_EXIT_A:    begin busAddr = AW'(ADR_EXIT);     busWdata = DW'(CMD_EXIT_A);    end
      SEL_EXIT_B:    begin busAddr = AW'(ADR_EXIT);     busWdata = DW'(CMD_EXIT_B);    end
      default:       begin busAddr = curAddr;           busWdata = dataReg;            end
    endcase
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollTimer < TW'(POLL_LIMIT)); // R7
  AST_ADVANCE_NOT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> remaining > CW'(1)); // R8

endmodule

// File: rtl/fpl_control.sv
module fpl_control
  import fpl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        bypassMode,
  input  logic        srcValid,
  input  logic        countZero,
  input  logic        isLast,
  input  logic        pollMatch,
  input  logic        verifyOk,
  input  logic        timeoutHit,
  output ctrlStrobe_t stb,
  output logic        srcReady,
  output logic        busWr,
  output logic        busRd,
  output logic        done,
  output logic        error
);

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_FETCH, S_CMD, S_POLL_RD, S_POLL_CHK,
    S_VER_RD, S_VER_CHK, S_EXIT, S_DONE, S_FAIL
  } state_e;

  state_e     state, stateNext;
  logic [1:0] step, stepNext;
  logic       bypassRun, bypassNext;
  logic [1:0] lastStep;
  busSel_e    cmdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      step      <= '0;
      bypassRun <= 1'b0;
    end else begin
      state     <= stateNext;
      step      <= stepNext;
      bypassRun <= bypassNext;
    end
  end

  assign lastStep = bypassRun ? 2'd1 : 2'd3;

  always_comb begin
    if (bypassRun) begin
      cmdSel = (step == 2'd0) ? SEL_PROG : SEL_WORD;
    end else begin
      case (step)
        2'd0:    cmdSel = SEL_UNLOCK_A;
        2'd1:    cmdSel = SEL_UNLOCK_B;
        2'd2:    cmdSel = SEL_PROG;
        default: cmdSel = SEL_WORD;
      endcase
    end
  end

  always_comb begin
    stateNext  = state;
    stepNext   = step;
    bypassNext = bypassRun;
    stb        = '0;
    stb.sel    = SEL_NONE;
    case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start) begin
          stb.loadStart = 1'b1;
          bypassNext    = bypassMode;
          stepNext      = '0;
          if (countZero)       stateNext = S_DONE;
          else if (bypassMode) stateNext = S_ENTER;
          else                 stateNext = S_FETCH;
        end
      end
      S_ENTER: begin
        stb.sel = (step == 2'd0) ? SEL_UNLOCK_A :
                  (step == 2'd1) ? SEL_UNLOCK_B : SEL_BYP_ENTER;
        if (step == 2'd2) begin
          stateNext = S_FETCH;
          stepNext  = '0;
        end else begin
          stepNext = step + 2'd1;
        end
      end
      S_FETCH: begin
        if (srcValid) begin
          stb.loadData = 1'b1;
          stateNext    = S_CMD;
          stepNext     = '0;
        end
      end
      S_CMD: begin
        stb.sel = cmdSel;
        if (step == lastStep) begin
          stb.clrTimer = 1'b1;
          stateNext    = S_POLL_RD;
        end else begin
          stepNext = step + 2'd1;
        end
      end
      S_POLL_RD: begin
        stb.sel   = SEL_READ;
        stateNext = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (pollMatch) begin
          stateNext = S_VER_RD;
        end else if (timeoutHit) begin
          stb.latchFail = 1'b1;
          stateNext     = S_FAIL;
        end else begin
          stb.incTimer = 1'b1;
          stateNext    = S_POLL_RD;
        end
      end
      S_VER_RD: begin
        stb.sel   = SEL_READ;
        stateNext = S_VER_CHK;
      end
      S_VER_CHK: begin
        if (!verifyOk) begin
          stb.latchFail = 1'b1;
          stateNext     = S_FAIL;
        end else if (!isLast) begin
          stb.advance = 1'b1;
          stateNext   = S_FETCH;
        end else if (bypassRun) begin
          stateNext = S_EXIT;
          stepNext  = '0;
        end else begin
          stateNext = S_DONE;
        end
      end
      S_EXIT: begin
        stb.sel = (step == 2'd0) ? SEL_EXIT_A : SEL_EXIT_B;
        if (step == 2'd1) stateNext = S_DONE;
        else              stepNext  = step + 2'd1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busWr    = (state == S_ENTER) || (state == S_CMD) || (state == S_EXIT);
  assign busRd    = (state == S_POLL_RD) || (state == S_VER_RD);
  assign srcReady = (state == S_FETCH);
  assign done     = (state == S_DONE);
  assign error    = (state == S_FAIL);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd)); // R11
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R11
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> !(busWr || busRd)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R11
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error); // R11
  AST_ERR_FROM_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(state == S_POLL_CHK || state == S_VER_CHK)); // R6

endmodule

// File: rtl/flash_prog_loop.sv
module flash_prog_loop
  import fpl_pkg::*;
#(
  parameter int AW         = 23,
  parameter int DW         = 16,
  parameter int CW         = 24,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          bypassMode,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] wordCount,
  input  logic [DW-1:0] srcData,
  input  logic          srcValid,
  output logic          srcReady,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          busWr,
  output logic          busRd,
  input  logic [DW-1:0] busRdata,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] failAddr
);

  ctrlStrobe_t stb;
  logic countZero, isLast, pollMatch, verifyOk, timeoutHit;

  fpl_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .bypassMode (bypassMode),
    .srcValid   (srcValid),
    .countZero  (countZero),
    .isLast     (isLast),
    .pollMatch  (pollMatch),
    .verifyOk   (verifyOk),
    .timeoutHit (timeoutHit),
    .stb        (stb),
    .srcReady   (srcReady),
    .busWr      (busWr),
    .busRd      (busRd),
    .done       (done),
    .error      (error)
  );

  fpl_datapath #(
    .AW(AW), .DW(DW), .CW(CW), .POLL_LIMIT(POLL_LIMIT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .startAddr  (startAddr),
    .wordCount  (wordCount),
    .srcData    (srcData),
    .busRdata   (busRdata),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .failAddr   (failAddr),
    .countZero  (countZero),
    .isLast     (isLast),
    .pollMatch  (pollMatch),
    .verifyOk   (verifyOk),
    .timeoutHit (timeoutHit)
  );

endmodule

// File: tb/flash_prog_loop_tb.sv
module flash_prog_loop_tb;

  localparam int AW    = 23;
  localparam int DW    = 16;
  localparam int CW    = 24;
  localparam int LIMIT = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          bypassMode = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] wordCount = '0;
  logic [DW-1:0] srcData = '0;
  logic          srcValid = 1'b0;
  logic          srcReady;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;
  logic          busWr, busRd;
  logic [DW-1:0] busRdata = '0;
  logic          done, error;
  logic [AW-1:0] failAddr;

  flash_prog_loop #(.AW(AW), .DW(DW), .CW(CW), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bypassMode(bypassMode),
    .startAddr(startAddr), .wordCount(wordCount), .srcData(srcData),
    .srcValid(srcValid), .srcReady(srcReady), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .done(done), .error(error), .failAddr(failAddr)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  bit            expWr[$];
  logic [AW-1:0] expAddr[$];
  logic [DW-1:0] expData[$];
  string         expTag[$];
  logic [DW-1:0] srcQ[$];

  int    cyc = 0;
  int    lastStrobeCyc = 0;
  int    riseDelta = -1;
  string riseTag = "R8";
  int    srcGap = 0;
  int    gapCnt = 0;
  bit    srcTaken = 0;
  int    taken = 0;
  bit    prevFlag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: expected bus sequence, responses and source, every clock
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (busWr && busRd) check(0, "R11", "both strobes", 1, 0);
      if (srcReady && (busWr || busRd)) check(0, "R9", "ready during strobe", 1, 0);
      if (busWr || busRd) begin
        lastStrobeCyc = cyc;
        if (expWr.size() == 0) begin
          check(0, "R11", "unexpected bus cycle at addr", longint'(busAddr), 0);
        end else begin
          automatic bit            w = expWr.pop_front();
          automatic logic [AW-1:0] a = expAddr.pop_front();
          automatic logic [DW-1:0] d = expData.pop_front();
          automatic string         t = expTag.pop_front();
          check(busWr == w, t, "strobe kind (1=write)", longint'(busWr), longint'(w));
          check(busAddr == a, t, "bus address", longint'(busAddr), longint'(a));
          if (w) check(busWdata == d, t, "write data", longint'(busWdata), longint'(d));
          else busRdata = d;
        end
      end
      if ((done || error) && !prevFlag && riseDelta >= 0)
        check(cyc - lastStrobeCyc == riseDelta, riseTag, "flag rise delay",
              longint'(cyc - lastStrobeCyc), longint'(riseDelta));
      prevFlag = done || error;
      if (srcTaken) begin
        srcTaken = 0;
        void'(srcQ.pop_front());
        gapCnt = srcGap;
      end
      if (gapCnt > 0) begin
        gapCnt--;
        srcValid = 1'b0;
      end else if (srcQ.size() > 0) begin
        srcValid = 1'b1;
        srcData  = srcQ[0];
      end else begin
        srcValid = 1'b0;
      end
      if (srcValid && srcReady) begin
        srcTaken = 1;
        taken++;
      end
    end
  end

  function automatic void pushOp(bit w, logic [AW-1:0] a, logic [DW-1:0] d, string t);
    expWr.push_back(w);
    expAddr.push_back(a);
    expData.push_back(d);
    expTag.push_back(t);
  endfunction

  function automatic logic [DW-1:0] wordData(int k);
    return DW'(16'h3C5A ^ (k * 16'h1111) ^ ((k % 2 == 1) ? 16'h0080 : 16'h0000));
  endfunction

  // busy: mismatching polls before a match (>= LIMIT means timeout)
  task automatic runCase(input bit byp, input logic [AW-1:0] sa, input int n,
                         input int busy[4], input int corruptIdx, input int gap);
    automatic bit stopped = 0;
    automatic int failK = -1;
    automatic bit isTimeout = 0;
    automatic int usedWords = 0;
    srcQ.delete();
    taken = 0;
    srcGap = gap;
    gapCnt = 0;
    if (byp && n > 0) begin
      pushOp(1, AW'(12'h555), DW'(8'hAA), "R3");
      pushOp(1, AW'(12'h2AA), DW'(8'h55), "R3");
      pushOp(1, AW'(12'h555), DW'(8'h20), "R3");
    end
    for (int k = 0; k < n && !stopped; k++) begin
      automatic logic [DW-1:0] d = wordData(k);
      automatic logic [AW-1:0] a = sa + AW'(k);
      srcQ.push_back(d);
      usedWords++;
      if (!byp) begin
        pushOp(1, AW'(12'h555), DW'(8'hAA), "R2");
        pushOp(1, AW'(12'h2AA), DW'(8'h55), "R2");
        pushOp(1, AW'(12'h555), DW'(8'hA0), "R2");
      end else begin
        pushOp(1, AW'(12'h555), DW'(8'hA0), "R3");
      end
      pushOp(1, a, d, byp ? "R3" : "R2");
      for (int p = 0; p < busy[k] && p < LIMIT; p++)
        pushOp(0, a, d ^ DW'(16'h0080), busy[k] >= LIMIT ? "R7" : "R5");
      if (busy[k] >= LIMIT) begin
        stopped = 1; failK = k; isTimeout = 1;
      end else begin
        pushOp(0, a, d, "R5");
        if (k == corruptIdx) begin
          pushOp(0, a, d ^ DW'(16'h0100), "R6");
          stopped = 1; failK = k;
        end else begin
          pushOp(0, a, d, "R8");
        end
      end
    end
    for (int k = usedWords; k < n; k++) srcQ.push_back(wordData(k));
    if (byp && !stopped && n > 0) begin
      pushOp(1, AW'(12'h000), DW'(8'h90), "R4");
      pushOp(1, AW'(12'h000), DW'(8'h00), "R4");
    end
    if (n == 0) riseDelta = -1;
    else if (stopped) begin riseDelta = 2; riseTag = isTimeout ? "R7" : "R6"; end
    else if (byp) begin riseDelta = 1; riseTag = "R4"; end
    else begin riseDelta = 2; riseTag = "R8"; end

    @(negedge clk);
    bypassMode = byp;
    startAddr  = sa;
    wordCount  = CW'(n);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, "R10", "done one cycle after start", longint'(done), 1);
    end
    for (int w = 0; w < 3000 && !(done || error); w++) @(negedge clk);
    repeat (4) @(negedge clk);
    if (stopped) begin
      check(error == 1'b1 && done == 1'b0, isTimeout ? "R7" : "R6", "error flag held",
            longint'({done, error}), 1);
      check(failAddr == sa + AW'(failK), isTimeout ? "R7" : "R6", "failing address",
            longint'(failAddr), longint'(sa + AW'(failK)));
    end else begin
      check(done == 1'b1 && error == 1'b0, n == 0 ? "R10" : "R11", "done flag held",
            longint'({done, error}), 2);
    end
    check(expWr.size() == 0, byp ? "R4" : "R8", "bus cycles still owed",
          longint'(expWr.size()), 0);
    check(taken == usedWords, "R9", "source words taken", longint'(taken),
          longint'(usedWords));
    check(busWr == 1'b0 && busRd == 1'b0 && srcReady == 1'b0, "R11", "quiet after end",
          longint'({busWr, busRd, srcReady}), 0);
    expWr.delete(); expAddr.delete(); expData.delete(); expTag.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busWr == 0 && busRd == 0 && srcReady == 0 && done == 0 && error == 0,
          "R1", "outputs in reset", longint'({busWr, busRd, srcReady, done, error}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busWr == 0 && busRd == 0 && srcReady == 0 && done == 0 && error == 0,
          "R1", "outputs after reset", longint'({busWr, busRd, srcReady, done, error}), 0);
    check(failAddr == '0, "R1", "failAddr after reset", longint'(failAddr), 0);

    // full mode, three words, mixed busy polls
    runCase(0, AW'(23'h000100), 3, '{0, 2, 1, 0}, -1, 0);
    // shortened mode, four words at top of space, poll match on read LIMIT, stalled source
    runCase(1, AW'(23'h7FFFFC), 4, '{1, 0, LIMIT - 1, 0}, -1, 2);
    // full mode, verify mismatch on second word
    runCase(0, AW'(23'h002000), 3, '{0, 1, 0, 0}, 1, 1);
    // shortened mode, poll timeout on first word
    runCase(1, AW'(23'h000040), 2, '{LIMIT, 0, 0, 0}, -1, 0);
    // zero count
    runCase(0, AW'(23'h000300), 0, '{0, 0, 0, 0}, -1, 0);
    // recovery after error/done: single word, full mode
    runCase(0, AW'(23'h000555), 1, '{3, 0, 0, 0}, -1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule